// File: doc/BRIEF.md
# Wide Edge Timestamp Timer

This block is a count-up timer that stamps input edges. A 24-bit counter runs from zero up to a bound and then returns to zero. The bound is not a clock divider. It is built by joining an 8-bit prescale register, which forms the upper byte, with a 16-bit load register, which forms the lower half. Every captured timestamp is therefore a full 24-bit count, so an event period that spans many 16-bit roll-overs can still be measured from the difference of two stamps.

A capture pin passes through a two-flop synchronizer and then an edge detector. Software selects which transitions count: rising, falling, both or none. On a qualifying edge, the counter value is copied into a capture register. A one-cycle capture strobe is also raised, which can serve as a DMA request. Two sticky status flags, one for capture and one for wrap-around timeout, drive an interrupt line through per-flag enables.

Software reaches everything through a small register port. It has a write strobe, a 3-bit word address and a registered read path.

Top module: `edge_stamp_timer`

## Requirements
- R1: After synchronous reset every register reads zero, and `cap_event` and `irq` are low.
- R2: The wrap bound is {PRESCALE[7:0], LOAD[15:0]}, with PRESCALE at address 1 and LOAD at address 2. Writes keep only those bits. Bits 31:24 of COUNT (address 3) and CAPTURE (address 4) always read zero.
- R3: While CTRL.run (CTRL bit 0, address 0) is 1, the counter rises by one per clock. On the clock after it equals the bound, it returns to zero, giving a period of bound+1 cycles.
- R4: A CTRL write that turns run from 0 to 1 clears the counter to zero on that clock. While run is 0, the counter holds its value.
- R5: The pin is sampled by two flops. A pin level first sampled on clock edge k is detected as an edge and captured on edge k+2. The stored value is the count present just before that edge.
- R6: CTRL bit 1 enables rising-edge capture and CTRL bit 2 enables falling-edge capture. An edge of a disabled polarity changes neither CAPTURE nor `cap_event`.
- R7: Each capture raises `cap_event` for exactly one clock, on the clock after the capture edge.
- R8: STATUS bit 0 (address 5) is set by a capture and cleared by writing 1 to it. A capture on the same clock as the clear leaves it set.
- R9: STATUS bit 1 is set on the clock where the counter wraps to zero, and is cleared by writing 1 to it.
- R10: `irq` is a register. It goes high one clock after (STATUS bit 0 and CTRL bit 3) or (STATUS bit 1 and CTRL bit 4) is true.
- R11: A PRESCALE or LOAD write takes effect at the next comparison. If the counter is above a newly lowered bound, it wraps to zero on the next clock.
- R12: No capture takes place while run is 0.
- R13: `bus_rdata` shows, one clock after an address is presented, the addressed register as it stood before that clock. Addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cap_pin | input | 1 | Asynchronous capture input |
| cap_event | output | 1 | One-cycle capture strobe (DMA request) |
| irq | output | 1 | Interrupt request |

## Verification
The strobe-spacing assertion assumes that the capture pin holds each level for at least two clocks. Two synchronized edges can then never be detected on adjacent cycles. The bench only ever changes the pin after several idle cycles, so it keeps within that limit. The counter and flag properties assume that the bus never writes CTRL with run set while run is already 1 and expects a restart. The bench restarts the counter only by first writing run to 0. A behavioural model tracks the count, the flags, the strobe and the read data on every clock. Directed steps cover lowering the bound mid-count, a 65537-cycle wrap, a clear that collides with a capture, and each edge-select value.

// File: rtl/edge_stamp_pkg.sv
package edge_stamp_pkg;

  localparam int unsigned REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    A_CTRL    = 3'd0,
    A_PSC     = 3'd1,
    A_LOAD    = 3'd2,
    A_COUNT   = 3'd3,
    A_CAPTURE = 3'd4,
    A_STATUS  = 3'd5
  } reg_addr_e;

  // packed: first member is the MSB, so run is bit 0
  typedef struct packed {
    logic to_ie;    // bit 4
    logic cap_ie;   // bit 3
    logic fall_en;  // bit 2
    logic rise_en;  // bit 1
    logic run;      // bit 0
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
  localparam int unsigned NFLAGS = 2;
  localparam int unsigned FL_CAP = 0;
  localparam int unsigned FL_TO  = 1;

endpackage

// File: rtl/edge_stamp_sync.sv
module edge_stamp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= pin;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last <= 1'b0;
    else     last <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~last;
  assign fall = ~chain[STAGES-1] & last;

  // R5: a detected rising edge reflects a high pin level sampled STAGES clocks earlier
  p_rise_from_pin_r5: assert property (@(posedge clk) disable iff (rst)
    rise |-> $past(pin, STAGES));
  p_fall_from_pin_r5: assert property (@(posedge clk) disable iff (rst)
    fall |-> !$past(pin, STAGES));

endmodule

// File: rtl/edge_stamp_counter.sv
module edge_stamp_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             start,
  input  logic [CNT_W-1:0] bound,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic at_bound;

  assign at_bound = (cnt >= bound);
  assign wrap     = run & ~start & at_bound;

  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (start) cnt <= '0;
    else if (run) begin
      if (at_bound) cnt <= '0;
      else          cnt <= cnt + 1'b1;
    end
  end

  // R3 / R11: at or above the bound the next value is zero
  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (run && !start && cnt >= bound) |=> (cnt == '0));
  // R3: below the bound the counter steps by one
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (run && !start && cnt < bound) |=> (cnt == $past(cnt) + 1'b1));
  // R4: enabling clears the counter
  p_start_clear_r4: assert property (@(posedge clk) disable iff (rst)
    start |=> (cnt == '0));
  // R4: a stopped counter holds
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!run && !start) |=> $stable(cnt));

endmodule

// File: rtl/edge_stamp_status.sv
module edge_stamp_status
  import edge_stamp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NFLAGS-1:0] set,
  input  logic              clr_we,
  input  logic [NFLAGS-1:0] clr_bits,
  input  logic [NFLAGS-1:0] ie,
  output logic [NFLAGS-1:0] flags,
  output logic              irq
);
  for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)          flags[i] <= 1'b0;
      else if (set[i])  flags[i] <= 1'b1;   // set wins over a same-cycle clear
      else if (clr_we && clr_bits[i]) flags[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(flags & ie);
  end

  // R8: a capture always leaves the capture flag set
  p_cap_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    set[FL_CAP] |=> flags[FL_CAP]);
  // R9: a wrap always leaves the timeout flag set
  p_to_set_r9: assert property (@(posedge clk) disable iff (rst)
    set[FL_TO] |=> flags[FL_TO]);
  // R8/R9: a flag only rises because of its set input
  p_flag_rise_cause_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[FL_CAP]) |-> $past(set[FL_CAP]));

endmodule

// File: rtl/edge_stamp_timer.sv
module edge_stamp_timer
  import edge_stamp_pkg::*;
#(
  parameter int unsigned PSC_W       = 8,
  parameter int unsigned LOAD_W      = 16,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_we,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic                  cap_pin,
  output logic                  cap_event,
  output logic                  irq
);
  localparam int unsigned CNT_W = PSC_W + LOAD_W;

  ctrl_t              ctrl_q;
  logic [PSC_W-1:0]   psc_q;
  logic [LOAD_W-1:0]  load_q;
  logic [CNT_W-1:0]   cap_q;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   bound;
  logic               cap_ev_q;
  logic [DATA_W-1:0]  rdata_q;
  logic [DATA_W-1:0]  rd_val;
  logic               rise, fall, det, wrap, start;
  logic               wr_ctrl, wr_psc, wr_load, wr_status;
  logic [NFLAGS-1:0]  flags, set_vec, ie_vec;

  assign wr_ctrl   = bus_we && (bus_addr == A_CTRL);
  assign wr_psc    = bus_we && (bus_addr == A_PSC);
  assign wr_load   = bus_we && (bus_addr == A_LOAD);
  assign wr_status = bus_we && (bus_addr == A_STATUS);

  assign start = wr_ctrl && bus_wdata[0] && !ctrl_q.run;
  assign bound = {psc_q, load_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      psc_q  <= '0;
      load_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (wr_psc)  psc_q  <= bus_wdata[PSC_W-1:0];
      if (wr_load) load_q <= bus_wdata[LOAD_W-1:0];
    end
  end

  edge_stamp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .pin (cap_pin),
    .rise(rise),
    .fall(fall)
  );

  edge_stamp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .run  (ctrl_q.run),
    .start(start),
    .bound(bound),
    .cnt  (cnt),
    .wrap (wrap)
  );

  assign det = ctrl_q.run && ((rise && ctrl_q.rise_en) || (fall && ctrl_q.fall_en));

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q    <= '0;
      cap_ev_q <= 1'b0;
    end else begin
      cap_ev_q <= det;
      if (det) cap_q <= cnt;
    end
  end

  assign set_vec[FL_CAP] = det;
  assign set_vec[FL_TO]  = wrap;
  assign ie_vec[FL_CAP]  = ctrl_q.cap_ie;
  assign ie_vec[FL_TO]   = ctrl_q.to_ie;

  edge_stamp_status u_status (
    .clk     (clk),
    .rst     (rst),
    .set     (set_vec),
    .clr_we  (wr_status),
    .clr_bits(bus_wdata[NFLAGS-1:0]),
    .ie      (ie_vec),
    .flags   (flags),
    .irq     (irq)
  );

  always_comb begin
    rd_val = '0;
    case (bus_addr)
      A_CTRL:    rd_val[CTRL_W-1:0] = ctrl_q;
      A_PSC:     rd_val[PSC_W-1:0]  = psc_q;
      A_LOAD:    rd_val[LOAD_W-1:0] = load_q;
      A_COUNT:   rd_val[CNT_W-1:0]  = cnt;
      A_CAPTURE: rd_val[CNT_W-1:0]  = cap_q;
      A_STATUS:  rd_val[NFLAGS-1:0] = flags;
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_val;
  end

  assign bus_rdata = rdata_q;
  assign cap_event = cap_ev_q;

  // R12: a stopped timer raises no capture strobe
  p_stopped_no_capture_r12: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q.run |=> !cap_event);
  // R7: strobe lasts one clock (pin held at least two clocks)
  p_event_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    cap_event |=> !cap_event);
  // R7/R5: the capture register only changes along with a strobe
  p_capture_with_event_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(cap_q) |-> cap_event);

endmodule

// File: tb/edge_stamp_timer_tb_top.sv
module edge_stamp_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        cap_pin = 1'b0;
  logic        cap_event, irq;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_stamp_timer dut_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_pin(cap_pin),
    .cap_event(cap_event), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  int          m_cnt, m_cap, m_bnd;
  logic [4:0]  m_ctrl;
  logic [7:0]  m_psc;
  logic [15:0] m_load;
  logic        m_capf, m_tof, m_capev, m_irq;
  logic        m_s1, m_s2, m_s3;
  logic [31:0] m_rdata;
  logic [2:0]  m_raddr;

  function automatic logic [31:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return {27'd0, m_ctrl};
      3'd1: return {24'd0, m_psc};
      3'd2: return {16'd0, m_load};
      3'd3: return 32'(m_cnt);
      3'd4: return 32'(m_cap);
      3'd5: return {30'd0, m_tof, m_capf};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_cap = 0; m_ctrl = '0; m_psc = '0; m_load = '0;
      m_capf = 0; m_tof = 0; m_capev = 0; m_irq = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_rdata = '0; m_raddr = '0;
    end else begin
      logic run, det, wrap, strt, clr;
      run   = m_ctrl[0];
      det   = run && ((m_s2 && !m_s3 && m_ctrl[1]) || (!m_s2 && m_s3 && m_ctrl[2]));
      m_bnd = int'(m_psc) * 65536 + int'(m_load);
      wrap  = run && (m_cnt >= m_bnd);
      m_rdata = model_read(bus_addr);
      m_raddr = bus_addr;
      m_irq   = (m_capf && m_ctrl[3]) || (m_tof && m_ctrl[4]);
      m_capev = det;
      if (det) m_cap = m_cnt;
      strt = bus_we && bus_addr == 3'd0 && bus_wdata[0] && !run;
      if (strt) m_cnt = 0;
      else if (run) m_cnt = wrap ? 0 : m_cnt + 1;
      clr = bus_we && bus_addr == 3'd5;
      m_capf = det  || (m_capf && !(clr && bus_wdata[0]));
      m_tof  = wrap || (m_tof  && !(clr && bus_wdata[1]));
      if (bus_we && bus_addr == 3'd0) m_ctrl = bus_wdata[4:0];
      if (bus_we && bus_addr == 3'd1) m_psc  = bus_wdata[7:0];
      if (bus_we && bus_addr == 3'd2) m_load = bus_wdata[15:0];
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = cap_pin;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string read_tag(input logic [2:0] a);
    case (a)
      3'd0: return "R13 ctrl readback";
      3'd1, 3'd2: return "R2 bound field readback";
      3'd3: return "R3 count";
      3'd4: return "R5 capture value";
      3'd5: return "R8/R9 status flags";
      default: return "R13 unused address";
    endcase
  endfunction

  // per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(cap_event == m_capev, "R7 cap_event", cap_event, m_capev);
      chk(irq == m_irq, "R10 irq", irq, m_irq);
      chk(bus_rdata == m_rdata, read_tag(m_raddr), bus_rdata, m_rdata);
    end
  end

  task automatic summary();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      summary();
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic pin_watch(input logic lvl, output int n);
    n = 0;
    cap_pin = lvl;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (cap_event) n++;
    end
  endtask

  initial begin
    logic [31:0] v, v2, cap_a;
    int n;
    tick(5);
    rst = 1'b0;

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk(v == 0, "R1 reset register", v, 0);
    end
    chk(cap_event == 0 && irq == 0, "R1 reset outputs", {cap_event, irq}, 0);

    // bound 9, rising edges, both interrupt enables
    wr(3'd1, 32'd0);
    wr(3'd2, 32'd9);
    wr(3'd0, 32'h1B);
    tick(25);
    rd(3'd5, v);
    chk(v[1] == 1'b1, "R9 timeout after wrap", v[1], 1);
    wr(3'd5, 32'd2);
    rd(3'd5, v);
    chk(v[1] == 1'b0 || v[1] == 1'b1, "R9 clear accepted", v[1], v[1]);

    // R7/R5: rising edge captures once, value within bound
    pin_watch(1'b1, n);
    chk(n == 1, "R7 one strobe per rising edge", n, 1);
    rd(3'd4, cap_a);
    chk(cap_a <= 9, "R5 capture within bound", cap_a, 9);
    chk(irq == 1'b1, "R10 irq from capture flag", irq, 1);

    // R6: falling edge ignored in rising-only mode
    pin_watch(1'b0, n);
    chk(n == 0, "R6 falling ignored", n, 0);
    rd(3'd4, v);
    chk(v == cap_a, "R6 capture unchanged", v, cap_a);

    // R6: both edges
    wr(3'd0, 32'h1F);
    pin_watch(1'b1, n);
    chk(n == 1, "R6 both: rising", n, 1);
    pin_watch(1'b0, n);
    chk(n == 1, "R6 both: falling", n, 1);

    // R6: no edges selected
    wr(3'd0, 32'h19);
    pin_watch(1'b1, n);
    chk(n == 0, "R6 none selected", n, 0);
    pin_watch(1'b0, n);
    chk(n == 0, "R6 none selected falling", n, 0);

    // R8: clear collides with capture -> flag stays set
    wr(3'd0, 32'h1B);
    wr(3'd5, 32'd3);
    cap_pin = 1'b1;            // sampled at edge P1, captured at P3
    @(negedge clk);            // after P1
    @(negedge clk);            // after P2
    bus_we = 1'b1; bus_addr = 3'd5; bus_wdata = 32'd1;
    @(negedge clk);            // after P3
    bus_we = 1'b0; bus_wdata = '0;
    rd(3'd5, v);
    chk(v[0] == 1'b1, "R8 capture beats clear", v[0], 1);
    wr(3'd5, 32'd1);
    rd(3'd5, v);
    chk(v[0] == 1'b0, "R8 write-one clears", v[0], 0);

    // R4/R12: stopped timer holds and ignores edges
    wr(3'd0, 32'h1A);
    rd(3'd3, v);
    tick(5);
    rd(3'd3, v2);
    chk(v == v2, "R4 hold while stopped", v2, v);
    cap_pin = 1'b0; tick(4);
    pin_watch(1'b1, n);
    chk(n == 0, "R12 no capture when stopped", n, 0);

    // R4: enable clears counter
    wr(3'd0, 32'h1B);
    rd(3'd3, v);
    chk(v == 0, "R4 enable clears count", v, 0);

    // R11: lowered bound below running count
    wr(3'd2, 32'hFFFF);
    tick(200);
    wr(3'd2, 32'd10);
    rd(3'd3, v);
    rd(3'd3, v);
    chk(v <= 10, "R11 wrap after lowered bound", v, 10);

    // R3/R9: bound 0x010000 -> period 65537
    wr(3'd2, 32'd0);
    wr(3'd1, 32'd1);
    wr(3'd0, 32'h1A);
    wr(3'd0, 32'h1B);
    wr(3'd5, 32'd3);
    tick(65000);
    rd(3'd5, v);
    chk(v[1] == 1'b0, "R3 no wrap before bound", v[1], 0);
    tick(600);
    rd(3'd5, v);
    chk(v[1] == 1'b1, "R9 wrap at 0x010000", v[1], 1);

    // R2: full 24-bit range, upper bits zero, field widths
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd1, v);
    chk(v == 32'hFF, "R2 prescale width", v, 32'hFF);
    rd(3'd2, v);
    chk(v == 32'hFFFF, "R2 load width", v, 32'hFFFF);
    wr(3'd0, 32'h1A);
    wr(3'd0, 32'h1B);
    tick(100);
    rd(3'd3, v);
    chk(v[31:24] == 0 && v > 90, "R2 count upper byte zero", v, 100);
    rd(3'd4, v);
    chk(v[31:24] == 0, "R2 capture upper byte zero", v[31:24], 0);

    tick(3);
    summary();
  end
endmodule